// File: doc/BRIEF.md
# Clock Control Unit with Low-Power Wait

This block turns an oscillator tick stream into two clock-enable strobes for a small microcontroller. The internal-clock strobe comes from the oscillator ticks, which can be halved first. The CPU-clock strobe is the internal strobe thinned by a programmable prescaler. Software can ask for an alternate clock input to drive the internal strobe. That request is honoured only while the alternate clock is reported present. A read-only status bit tells software whether the switch has really happened.

Two register bytes sit behind a simple synchronous bus: a mode byte and a control byte. The control byte decides three things: how wait-for-interrupt behaves, whether halt powers the clock unit down or requests a reset, and which interrupt line is routed to the core. In plain wait the CPU strobe stops and the internal strobe runs on. In low-power wait the internal strobe drops to the main clock divided by a parameter (16 by default), or moves to the alternate clock. Choosing the alternate clock for low-power wait sets the alternate-select bit in hardware. The alternate clock therefore stays the system clock after wake-up until software clears that bit. Oscillator, PLL and clock-presence detection lie outside the block: each arrives as a tick or as an already-synchronized flag.

Top module: `clkctl_unit`

## Requirements
- R1: After reset, the mode byte (address 0) reads E0h, the control byte (address 1) reads 00h and the status byte (address 2) reads 00h. Read data appears on `bus_rdata` the cycle after a read and is held until the next read.
- R2: Mode bit 5 is the halving control. When it is 0, `int_en` pulses on every `osc_tick`. When it is 1, `int_en` pulses on every second `osc_tick`: the second, fourth and so on after reset.
- R3: Mode bits 4:2 form the prescale value P. `cpu_en` pulses on every (P+1)-th `int_en` pulse while the core runs, so P=0 passes every pulse. `cpu_en` is never high without `int_en`.
- R4: Control bits 6:4 always read as zero, and writes to them are discarded.
- R5: Control bit 2 requests the alternate clock. The switch to `alt_tick` as the internal source happens only while `alt_present` is 1, and only in a cycle in which the current source gives an `int_en` pulse. Status bit 0 reads 1 while the alternate clock is in use. Losing `alt_present` drops back to the main clock on the next cycle.
- R6: Plain wait is entered with `wfi_req` while control bit 0 is 0. During this wait `cpu_en` stays low and `int_en` keeps its running behaviour. `in_wait` is 1 during wait.
- R7: Low-power wait is entered with `wfi_req` while control bit 0 is 1 and the alternate clock is not in use. During this wait `int_en` pulses once per 16 main ticks: the 16th, 32nd and so on counted from entry.
- R8: Entering wait with control bits 0 and 1 both set makes hardware set control bit 2. The alternate clock therefore stays selected after wake-up until software clears bit 2.
- R9: Wait ends in the cycle after `irq_req` is high.
- R10: `halt_req` while control bit 3 is 1 gives a one-cycle `rst_req` pulse in the following cycle.
- R11: `halt_req` while control bit 3 is 0 raises `osc_off` from the next cycle. `osc_off` and the silence of both strobes last until `rst_n` is asserted, and that reset restores both register bytes.
- R12: `irq_req` follows `ext_irq` when control bit 7 is 0, and follows `int_irq` when control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 mode, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| osc_tick | input | 1 | One-cycle tick per oscillator period |
| alt_tick | input | 1 | One-cycle tick per alternate clock period |
| alt_present | input | 1 | Synchronized alternate-clock presence flag |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| halt_req | input | 1 | Halt request pulse |
| ext_irq | input | 1 | External interrupt line |
| int_irq | input | 1 | Internal interrupt line of the unit |
| irq_req | output | 1 | Selected interrupt request |
| int_en | output | 1 | Internal clock enable strobe |
| cpu_en | output | 1 | CPU clock enable strobe |
| rst_req | output | 1 | Reset request pulse after halt |
| osc_off | output | 1 | Oscillator, PLL and clock unit powered down |
| in_wait | output | 1 | Core is in wait |

## Verification
`int_en`, `cpu_en` and `irq_req` are combinational from the input ticks and registered state, so each is due in the same cycle as its tick. Register writes, wait entry, wait exit, source switches and `osc_off` take effect from the cycle after their trigger edge. `rst_req` and read data appear one cycle after the request. The bench drives inputs at the falling edge and samples 1 ns later against a cycle-accurate bench model. That model is advanced at every rising edge, so every expected value sits in the same cycle as the output it checks.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_MODE = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

   // mode byte fields
   localparam int MB_HALVE  = 5;
   localparam int MB_PRS_LO = 2;
   localparam logic [7:0] MODE_RST = 8'hE0;

   // control byte fields
   localparam int CB_IRQSEL = 7;
   localparam int CB_HALTRST = 3;
   localparam int CB_ALTREQ = 2;
   localparam int CB_WAITALT = 1;
   localparam int CB_LPWAIT = 0;
   localparam logic [7:0] CTRL_KEEP = 8'h8F;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_WAIT = 2'd1,
      PS_DOWN = 2'd2
   } pwr_state_t;

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int DW    = 8,
   parameter int PRS_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              set_alt,
   input  logic              alt_active,
   output logic              halve,
   output logic [PRS_W-1:0]  prs,
   output logic              irq_sel,
   output logic              halt_rst,
   output logic              alt_req,
   output logic              wait_alt,
   output logic              lp_wait_en
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("clkctl_regs: DW must be 8");
      end
      if (PRS_W < 1 || MB_PRS_LO + PRS_W > MB_HALVE) begin : g_bad_prs
         $error("clkctl_regs: PRS_W must fit below the halving bit");
      end
   endgenerate

   logic [DW-1:0] mode_q;
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] rd_mux;

   always_comb begin
      case (addr)
         ADR_MODE: rd_mux = mode_q;
         ADR_CTRL: rd_mux = ctrl_q;
         ADR_STAT: rd_mux = {{(DW-1){1'b0}}, alt_active};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         ctrl_q <= '0;
         rdata  <= '0;
      end else begin
         if (wr && addr == ADR_MODE) mode_q <= wdata;
         if (wr && addr == ADR_CTRL) ctrl_q <= wdata & CTRL_KEEP;
         // hardware set on low-power wait entry wins over a same-cycle write
         if (set_alt) ctrl_q[CB_ALTREQ] <= 1'b1;
         if (rd) rdata <= rd_mux;
      end
   end

   assign halve      = mode_q[MB_HALVE];
   assign prs        = mode_q[MB_PRS_LO +: PRS_W];
   assign irq_sel    = ctrl_q[CB_IRQSEL];
   assign halt_rst   = ctrl_q[CB_HALTRST];
   assign alt_req    = ctrl_q[CB_ALTREQ];
   assign wait_alt   = ctrl_q[CB_WAITALT];
   assign lp_wait_en = ctrl_q[CB_LPWAIT];

endmodule

// File: rtl/clkctl_clkgen.sv
module clkctl_clkgen #(
   parameter int LP_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic alt_tick,
   input  logic alt_present,
   input  logic halve,
   input  logic alt_req,
   input  logic lp_wait,
   input  logic down,
   output logic int_en,
   output logic use_alt
);

   localparam int LPC_W = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;

   logic ph_q;
   logic main_tick;
   logic lp_hit;

   assign main_tick = osc_tick & (~halve | ph_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ph_q <= 1'b0;
      else if (!down && osc_tick) ph_q <= ~ph_q;
   end

   generate
      if (LP_DIV < 1) begin : g_bad_lp
         $error("clkctl_clkgen: LP_DIV must be at least 1");
      end
      if (LP_DIV == 1) begin : g_lp_pass
         assign lp_hit = 1'b1;
      end else begin : g_lp_cnt
         localparam logic [LPC_W-1:0] LP_LAST = LPC_W'(LP_DIV - 1);
         logic [LPC_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (!lp_wait)  cnt_q <= '0;
            else if (main_tick) cnt_q <= (cnt_q == LP_LAST) ? '0 : cnt_q + 1'b1;
         end
         assign lp_hit = (cnt_q == LP_LAST);
      end
   endgenerate

   always_comb begin
      if (down)         int_en = 1'b0;
      else if (use_alt) int_en = alt_tick;
      else if (lp_wait) int_en = main_tick & lp_hit;
      else              int_en = main_tick;
   end

   // source changes only after a strobe of the current source
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          use_alt <= 1'b0;
      else if (!alt_present)               use_alt <= 1'b0;
      else if (alt_req != use_alt && int_en) use_alt <= alt_req;
   end

endmodule

// File: rtl/clkctl_presc.sv
module clkctl_presc #(
   parameter int PRS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [PRS_W-1:0] prs,
   output logic             cpu_en
);

   logic [PRS_W-1:0] cnt_q;
   logic             hit;

   assign hit    = (cnt_q >= prs);
   assign cpu_en = run & tick & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (run && tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/clkctl_pwr.sv
module clkctl_pwr
   import clkctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wfi_req,
   input  logic halt_req,
   input  logic irq_req,
   input  logic halt_rst,
   input  logic lp_wait_en,
   input  logic wait_alt,
   output logic run,
   output logic in_wait,
   output logic lp_wait,
   output logic down,
   output logic set_alt,
   output logic rst_req
);

   pwr_state_t state_q;
   logic       lp_q;

   assign run     = (state_q == PS_RUN);
   assign in_wait = (state_q == PS_WAIT);
   assign down    = (state_q == PS_DOWN);
   assign lp_wait = in_wait & lp_q;
   assign set_alt = run & ~halt_req & wfi_req & lp_wait_en & wait_alt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_RUN;
         lp_q    <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= run & halt_req & halt_rst;
         case (state_q)
            PS_RUN: begin
               if (halt_req) begin
                  if (!halt_rst) state_q <= PS_DOWN;
               end else if (wfi_req) begin
                  state_q <= PS_WAIT;
                  lp_q    <= lp_wait_en;
               end
            end
            PS_WAIT: begin
               if (irq_req) begin
                  state_q <= PS_RUN;
                  lp_q    <= 1'b0;
               end
            end
            default: state_q <= PS_DOWN;
         endcase
      end
   end

endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
   import clkctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PRS_W  = 3,
   parameter int LP_DIV = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              osc_tick,
   input  logic              alt_tick,
   input  logic              alt_present,
   input  logic              wfi_req,
   input  logic              halt_req,
   input  logic              ext_irq,
   input  logic              int_irq,
   output logic              irq_req,
   output logic              int_en,
   output logic              cpu_en,
   output logic              rst_req,
   output logic              osc_off,
   output logic              in_wait
);

   logic             halve, irq_sel, halt_rst, alt_req, wait_alt, lp_wait_en;
   logic [PRS_W-1:0] prs;
   logic             run, lp_wait, down, set_alt, use_alt;

   assign irq_req = irq_sel ? int_irq : ext_irq;
   assign osc_off = down;

   clkctl_regs #(.DW(DATA_W), .PRS_W(PRS_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .rdata      (bus_rdata),
      .set_alt    (set_alt),
      .alt_active (use_alt),
      .halve      (halve),
      .prs        (prs),
      .irq_sel    (irq_sel),
      .halt_rst   (halt_rst),
      .alt_req    (alt_req),
      .wait_alt   (wait_alt),
      .lp_wait_en (lp_wait_en)
   );

   clkctl_clkgen #(.LP_DIV(LP_DIV)) i_clkgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_tick    (osc_tick),
      .alt_tick    (alt_tick),
      .alt_present (alt_present),
      .halve       (halve),
      .alt_req     (alt_req),
      .lp_wait     (lp_wait),
      .down        (down),
      .int_en      (int_en),
      .use_alt     (use_alt)
   );

   clkctl_presc #(.PRS_W(PRS_W)) i_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (int_en),
      .run    (run),
      .prs    (prs),
      .cpu_en (cpu_en)
   );

   clkctl_pwr i_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wfi_req    (wfi_req),
      .halt_req   (halt_req),
      .irq_req    (irq_req),
      .halt_rst   (halt_rst),
      .lp_wait_en (lp_wait_en),
      .wait_alt   (wait_alt),
      .run        (run),
      .in_wait    (in_wait),
      .lp_wait    (lp_wait),
      .down       (down),
      .set_alt    (set_alt),
      .rst_req    (rst_req)
   );

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
   input logic clk,
   input logic rst_n,
   input logic int_en,
   input logic cpu_en,
   input logic in_wait,
   input logic irq_req,
   input logic osc_off,
   input logic rst_req,
   input logic alt_present,
   input logic use_alt
);

   a_r3_cpu_within_int: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_en |-> int_en);

   a_r6_wait_stops_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait |-> !cpu_en);

   a_r9_wake_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && irq_req) |=> !in_wait);

   a_r10_single_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r11_down_silent: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off |-> (!int_en && !cpu_en && !in_wait));

   a_r11_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off |=> osc_off);

   a_r5_alt_needs_presence: assert property (@(posedge clk) disable iff (!rst_n)
      !alt_present |=> !use_alt);

endmodule

bind clkctl_unit clkctl_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .int_en      (int_en),
   .cpu_en      (cpu_en),
   .in_wait     (in_wait),
   .irq_req     (irq_req),
   .osc_off     (osc_off),
   .rst_req     (rst_req),
   .alt_present (alt_present),
   .use_alt     (use_alt)
);

// File: tb/test_clkctl_unit.sv
`timescale 1ns/1ps
module test_clkctl_unit;

   localparam int LPD = 16;
   localparam int MAX_CYC = 200000;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n, bus_wr, bus_rd;
   logic [1:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic       osc_tick, alt_tick, alt_present, wfi_req, halt_req, ext_irq, int_irq;
   logic       irq_req, int_en, cpu_en, rst_req, osc_off, in_wait;

   clkctl_unit i_clkctl_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .osc_tick(osc_tick), .alt_tick(alt_tick), .alt_present(alt_present),
      .wfi_req(wfi_req), .halt_req(halt_req), .ext_irq(ext_irq), .int_irq(int_irq),
      .irq_req(irq_req), .int_en(int_en), .cpu_en(cpu_en), .rst_req(rst_req),
      .osc_off(osc_off), .in_wait(in_wait)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // drive values
   logic       d_rst = 0, d_wr = 0, d_rd = 0, d_osc = 0, d_alt = 0, d_pres = 0;
   logic       d_wfi = 0, d_halt = 0, d_ext = 0, d_int = 0;
   logic [1:0] d_addr = 0;
   logic [7:0] d_wdata = 0;

   // bench model state
   logic [7:0] m_mode, m_ctrl, m_rdata;
   logic       m_ph, m_use_alt, m_lp, m_rstq;
   int         m_lpc, m_pcnt, m_state;   // state: 0 run, 1 wait, 2 down

   // sampled outputs and counters
   int s_int, s_cpu, s_irq, s_rst, s_off, s_wait, s_rdata;
   int c_int, c_cpu;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = 8'hE0; m_ctrl = 8'h00; m_rdata = 8'h00;
      m_ph = 0; m_use_alt = 0; m_lp = 0; m_rstq = 0;
      m_lpc = 0; m_pcnt = 0; m_state = 0;
   endtask

   function automatic logic f_main();
      return d_osc & (!m_mode[5] | m_ph);
   endfunction

   function automatic logic f_int();
      if (m_state == 2) return 1'b0;
      if (m_use_alt) return d_alt;
      if (m_state == 1 && m_lp) return f_main() && (m_lpc == LPD-1);
      return f_main();
   endfunction

   function automatic logic f_cpu();
      return (m_state == 0) && f_int() && (m_pcnt >= int'(m_mode[4:2]));
   endfunction

   function automatic logic f_irq();
      return m_ctrl[7] ? d_int : d_ext;
   endfunction

   task automatic model_step();
      logic       e_main, e_int, e_irq, run, set_alt;
      logic [7:0] n_ctrl;
      e_main = f_main(); e_int = f_int(); e_irq = f_irq();
      run = (m_state == 0);
      set_alt = run && !d_halt && d_wfi && m_ctrl[0] && m_ctrl[1];
      if (d_rd) m_rdata = (d_addr == 0) ? m_mode : (d_addr == 1) ? m_ctrl :
                          (d_addr == 2) ? {7'd0, m_use_alt} : 8'h00;
      if (!(m_state == 1 && m_lp)) m_lpc = 0;
      else if (e_main) m_lpc = (m_lpc == LPD-1) ? 0 : m_lpc + 1;
      if (m_state != 2 && d_osc) m_ph = ~m_ph;
      if (!d_pres) m_use_alt = 0;
      else if (m_ctrl[2] != m_use_alt && e_int) m_use_alt = m_ctrl[2];
      if (run && e_int) m_pcnt = (m_pcnt >= int'(m_mode[4:2])) ? 0 : m_pcnt + 1;
      m_rstq = run && d_halt && m_ctrl[3];
      n_ctrl = m_ctrl;
      if (m_state == 0) begin
         if (d_halt) begin
            if (!m_ctrl[3]) m_state = 2;
         end else if (d_wfi) begin
            m_state = 1; m_lp = m_ctrl[0];
         end
      end else if (m_state == 1) begin
         if (e_irq) begin m_state = 0; m_lp = 0; end
      end
      if (d_wr && d_addr == 0) m_mode = d_wdata;
      if (d_wr && d_addr == 1) n_ctrl = d_wdata & 8'h8F;
      if (set_alt) n_ctrl[2] = 1'b1;
      m_ctrl = n_ctrl;
   endtask

   task automatic cycle();
      @(negedge clk);
      rst_n = d_rst; bus_wr = d_wr; bus_rd = d_rd; bus_addr = d_addr; bus_wdata = d_wdata;
      osc_tick = d_osc; alt_tick = d_alt; alt_present = d_pres; wfi_req = d_wfi;
      halt_req = d_halt; ext_irq = d_ext; int_irq = d_int;
      #1;
      if (!d_rst) model_reset();
      s_int = int'(int_en); s_cpu = int'(cpu_en); s_irq = int'(irq_req);
      s_rst = int'(rst_req); s_off = int'(osc_off); s_wait = int'(in_wait);
      s_rdata = int'(bus_rdata);
      chk("R2 int_en", s_int, int'(f_int()));
      chk("R3 cpu_en", s_cpu, int'(f_cpu()));
      chk("R12 irq_req", s_irq, int'(f_irq()));
      chk("R10 rst_req", s_rst, int'(m_rstq));
      chk("R11 osc_off", s_off, int'(m_state == 2));
      chk("R9 in_wait", s_wait, int'(m_state == 1));
      chk("R1 bus_rdata", s_rdata, int'(m_rdata));
      c_int += s_int; c_cpu += s_cpu;
      @(posedge clk);
      if (d_rst) model_step();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] v);
      d_wr = 1; d_addr = a; d_wdata = v; cycle(); d_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      d_rd = 1; d_addr = a; cycle(); d_rd = 0; cycle(); v = s_rdata;
   endtask

   task automatic pulse_wfi(); d_wfi = 1; cycle(); d_wfi = 0; endtask
   task automatic wake();      d_ext = 1; cycle(); d_ext = 0; cycle(); endtask

   initial begin
      #(MAX_CYC * 8);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int v;
      model_reset();
      d_rst = 0; cycle(); cycle(); d_rst = 1; cycle();

      // R1 reset values
      rd(2'd0, v); chk("R1 mode reset", v, 'hE0);
      rd(2'd1, v); chk("R1 ctrl reset", v, 'h00);
      rd(2'd2, v); chk("R1 status reset", v, 'h00);

      // R4 reserved bits
      wr(2'd1, 8'hFF); rd(2'd1, v); chk("R4 reserved read zero", v, 'h8F);
      wr(2'd1, 8'h00);

      // R2 halving on (reset value) then off
      d_osc = 1; c_int = 0; repeat (20) cycle(); chk("R2 halved count", c_int, 10);
      wr(2'd0, 8'h00); c_int = 0; repeat (20) cycle(); chk("R2 undivided count", c_int, 20);

      // R3 prescale 3 -> divide by 4
      wr(2'd0, 8'h0C); c_cpu = 0; repeat (40) cycle(); chk("R3 prescaled count", c_cpu, 10);

      // R6 plain wait
      pulse_wfi(); c_int = 0; c_cpu = 0; repeat (10) cycle();
      chk("R6 int runs in wait", c_int, 10); chk("R6 cpu stopped", c_cpu, 0);
      chk("R6 in_wait", s_wait, 1);
      wake(); chk("R9 woke", s_wait, 0);

      // R7 low-power wait, main/16
      wr(2'd0, 8'h00); wr(2'd1, 8'h01); pulse_wfi();
      c_int = 0; c_cpu = 0; repeat (64) cycle();
      chk("R7 lp int count", c_int, 4); chk("R7 lp cpu", c_cpu, 0);
      wake(); chk("R9 woke lp", s_wait, 0);

      // R5 alternate selection only when present
      wr(2'd1, 8'h04); d_alt = 1; repeat (4) cycle();
      rd(2'd2, v); chk("R5 absent no switch", v, 0);
      d_pres = 1; repeat (4) cycle();
      rd(2'd2, v); chk("R5 switched", v, 1);
      d_alt = 0; c_int = 0; repeat (10) cycle(); chk("R5 alt is source", c_int, 0);
      wr(2'd1, 8'h00); repeat (3) cycle();
      rd(2'd2, v); chk("R5 waits for boundary", v, 1);
      d_alt = 1; cycle(); d_alt = 0;
      rd(2'd2, v); chk("R5 back to main", v, 0);

      // R8 low-power wait on alternate, sticky after wake
      d_alt = 1; wr(2'd1, 8'h03); pulse_wfi(); repeat (20) cycle();
      rd(2'd1, v); chk("R8 select set by hw", v, 'h07);
      wake(); rd(2'd2, v); chk("R8 sticky after wake", v, 1);
      wr(2'd1, 8'h00); repeat (2) cycle();
      rd(2'd2, v); chk("R8 cleared by software", v, 0);

      // R12 interrupt steering
      wr(2'd1, 8'h80); d_int = 1; d_ext = 0; cycle(); chk("R12 internal", s_irq, 1);
      d_int = 0; d_ext = 1; cycle(); chk("R12 ext ignored", s_irq, 0);
      wr(2'd1, 8'h00); cycle(); chk("R12 external", s_irq, 1);
      d_ext = 0;

      // R10 halt requests reset
      wr(2'd1, 8'h08); d_halt = 1; cycle(); d_halt = 0;
      cycle(); chk("R10 reset pulse", s_rst, 1); chk("R10 no power down", s_off, 0);
      cycle(); chk("R10 pulse ends", s_rst, 0);

      // R11 halt powers down until reset
      wr(2'd1, 8'h00); d_halt = 1; cycle(); d_halt = 0;
      c_int = 0; repeat (10) cycle();
      chk("R11 osc_off", s_off, 1); chk("R11 silent", c_int, 0);
      d_wfi = 1; d_ext = 1; cycle(); d_wfi = 0; d_ext = 0;
      chk("R11 still down", s_off, 1);
      d_rst = 0; cycle(); d_rst = 1; cycle();
      chk("R11 reset clears", s_off, 0);
      rd(2'd0, v); chk("R11 mode restored", v, 'hE0);

      // constrained random phase
      void'($urandom(32'd2024));
      begin
         int down_cnt = 0;
         for (int i = 0; i < 4000; i++) begin
            d_osc  = ($urandom % 100) < 60;
            d_alt  = ($urandom % 100) < 30;
            if (($urandom % 100) < 2) d_pres = ~d_pres;
            d_ext  = ($urandom % 100) < 5;
            d_int  = ($urandom % 100) < 5;
            d_wfi  = ($urandom % 100) < 3;
            d_halt = ($urandom % 1000) < 5;
            d_wr   = ($urandom % 100) < 6;
            d_rd   = !d_wr && (($urandom % 100) < 10);
            d_addr = 2'($urandom % 4);
            d_wdata = 8'($urandom);
            down_cnt = (m_state == 2) ? down_cnt + 1 : 0;
            d_rst = !(down_cnt > 12);
            cycle();
         end
      end
      d_rst = 1; d_wr = 0; d_rd = 0; d_wfi = 0; d_halt = 0;
      cycle();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule